// File: doc/BRIEF.md
# Load/Store Alignment Exception Checker

This block sits beside a load/store unit and judges every memory-access request for an alignment exception. The unit presents a decoded instruction class, the low bits of the effective address, the access size, the current byte-order mode and the write-through and caching-inhibited attributes of the target. One clock later the block shows a fault flag and the effective address it captured. Exception logic can copy that address into a status register.

The alignment rule depends on the instruction class, not on one natural-alignment test. Word-granular classes check only the two low address bits. Single-register accesses matter only in little-endian mode. Multiple and string forms are refused outright in little-endian mode. Cache-block zero depends only on the memory attributes. Opcode decoding and address translation are done elsewhere.

Top module: `lsu_align_check`

## Requirements
- R1: While the reset input is low, and after it is asserted at any time, `fault_o` is 0 and `fault_ea_o` is 0, whatever the request inputs carry.
- R2: Class code 1 (floating-point load/store) faults exactly when address bits [1:0] are not both zero.
- R3: Class code 2 (load/store multiple) faults when address bits [1:0] are not both zero, or when `little_endian_i` is 1.
- R4: Class code 3 (reserved load / conditional store) faults exactly when address bits [1:0] are not both zero.
- R5: Class code 4 (string load/store) faults exactly when `little_endian_i` is 1, for any address.
- R6: Class code 0 (single-register load/store) faults exactly when `little_endian_i` is 1 and the address is not a multiple of the access size. The size is coded on `req_size_i` as 0=1, 1=2, 2=4 and 3=8 bytes.
- R7: Class code 5 (cache-block zero) faults exactly when `wr_thru_i` or `cache_inh_i` is 1, for any address and byte order.
- R8: Class codes 6 and 7 never fault.
- R9: On the first rising clock edge after a request with `req_valid_i` high, `fault_o` takes that request's verdict and `fault_ea_o` takes its full effective address.
- R10: A cycle with `req_valid_i` low leaves `fault_o` and `fault_ea_o` unchanged. An invalid request therefore never raises the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid_i | input | 1 | A request is present this cycle |
| req_class_i | input | 3 | Decoded instruction class code (see R2 to R8) |
| req_ea_i | input | ADDR_W | Effective address of the access |
| req_size_i | input | 2 | Access size as log2 of the byte count |
| little_endian_i | input | 1 | 1 when little-endian mode is active |
| wr_thru_i | input | 1 | Target requires write-through |
| cache_inh_i | input | 1 | Target is caching-inhibited |
| fault_o | output | 1 | Registered alignment-fault flag |
| fault_ea_o | output | ADDR_W | Effective address captured with the last valid request |

## Verification
The verdict and the captured address both come from one register stage. Both are due at the first rising edge after a valid request. The bench drives each request on a falling edge and reads both outputs at the next falling edge, half a period after they update. The hold checks issue invalid cycles after both a clean verdict and a faulting one, and read the outputs again at later falling edges. The reset checks read the outputs during reset and one nanosecond after a mid-run assertion of reset, since that clear does not wait for a clock.

// File: rtl/lac_pkg.sv
package lac_pkg;
  // access size coding: log2 of the byte count
  localparam int SIZE_W = 2;
  localparam int NSIZE  = 1 << SIZE_W;
  // low address bits needed to judge the widest access
  localparam int LOW_W  = NSIZE - 1;
  // word alignment is judged on this many low bits
  localparam int WORD_LG = 2;

  localparam int CLS_W  = 3;
  localparam int NCLASS = 1 << CLS_W;

  typedef logic [CLS_W-1:0] cls_t;

  localparam cls_t CLS_SINGLE = 3'd0;
  localparam cls_t CLS_FP     = 3'd1;
  localparam cls_t CLS_MULT   = 3'd2;
  localparam cls_t CLS_RSV    = 3'd3;
  localparam cls_t CLS_STR    = 3'd4;
  localparam cls_t CLS_ZERO   = 3'd5;
endpackage

// File: rtl/lac_rst_sync.sv
module lac_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= 2'b00;
    else          sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/lac_misalign.sv
module lac_misalign
  import lac_pkg::*;
(
  input  logic [LOW_W-1:0]  ea_lo_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              word_mis_o,
  output logic              nat_mis_o
);
  // mis_by_size[s]: address is not a multiple of 2**s bytes
  logic [NSIZE-1:0] mis_by_size;

  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    if (s == 0) begin : g_byte
      assign mis_by_size[s] = 1'b0;
    end else begin : g_wide
      assign mis_by_size[s] = |ea_lo_i[s-1:0];
    end
  end

  assign word_mis_o = mis_by_size[WORD_LG];
  assign nat_mis_o  = mis_by_size[size_i];
endmodule

// File: rtl/lac_rule_eval.sv
module lac_rule_eval
  import lac_pkg::*;
(
  input  cls_t class_i,
  input  logic word_mis_i,
  input  logic nat_mis_i,
  input  logic little_endian_i,
  input  logic wr_thru_i,
  input  logic cache_inh_i,
  output logic fault_o
);
  logic [NCLASS-1:0] hit;

  for (genvar c = 0; c < NCLASS; c++) begin : g_cls
    if (c == int'(CLS_SINGLE)) begin : g_single
      assign hit[c] = little_endian_i & nat_mis_i;
    end else if (c == int'(CLS_FP)) begin : g_fp
      assign hit[c] = word_mis_i;
    end else if (c == int'(CLS_MULT)) begin : g_mult
      assign hit[c] = word_mis_i | little_endian_i;
    end else if (c == int'(CLS_RSV)) begin : g_rsv
      assign hit[c] = word_mis_i;
    end else if (c == int'(CLS_STR)) begin : g_str
      assign hit[c] = little_endian_i;
    end else if (c == int'(CLS_ZERO)) begin : g_zero
      assign hit[c] = wr_thru_i | cache_inh_i;
    end else begin : g_none
      assign hit[c] = 1'b0;
    end
  end

  assign fault_o = hit[class_i];
endmodule

// File: rtl/lac_capture.sv
module lac_capture #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              fault_i,
  input  logic [ADDR_W-1:0] ea_i,
  output logic              fault_o,
  output logic [ADDR_W-1:0] ea_o
);
  logic              fault_q, fault_d;
  logic [ADDR_W-1:0] ea_q, ea_d;

  always_comb begin
    fault_d = fault_q;
    ea_d    = ea_q;
    if (en_i) begin
      fault_d = fault_i;
      ea_d    = ea_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      ea_q    <= '0;
    end else begin
      fault_q <= fault_d;
      ea_q    <= ea_d;
    end
  end

  assign fault_o = fault_q;
  assign ea_o    = ea_q;

  // R10: with the enable low, the stored verdict and address do not move
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(fault_o) && $stable(ea_o))
    else $error("p_hold_r10");
endmodule

// File: rtl/lsu_align_check.sv
module lsu_align_check
  import lac_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [CLS_W-1:0]  req_class_i,
  input  logic [ADDR_W-1:0] req_ea_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic              little_endian_i,
  input  logic              wr_thru_i,
  input  logic              cache_inh_i,
  output logic              fault_o,
  output logic [ADDR_W-1:0] fault_ea_o
);
  logic rst_q_n;
  logic word_mis, nat_mis;
  logic fault_d;

  lac_rst_sync u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_q_n)
  );

  lac_misalign u_mis (
    .ea_lo_i    (req_ea_i[LOW_W-1:0]),
    .size_i     (req_size_i),
    .word_mis_o (word_mis),
    .nat_mis_o  (nat_mis)
  );

  lac_rule_eval u_rule (
    .class_i         (cls_t'(req_class_i)),
    .word_mis_i      (word_mis),
    .nat_mis_i       (nat_mis),
    .little_endian_i (little_endian_i),
    .wr_thru_i       (wr_thru_i),
    .cache_inh_i     (cache_inh_i),
    .fault_o         (fault_d)
  );

  lac_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_q_n),
    .en_i    (req_valid_i),
    .fault_i (fault_d),
    .ea_i    (req_ea_i),
    .fault_o (fault_o),
    .ea_o    (fault_ea_o)
  );

  // R9: the captured address follows a valid request by one edge
  p_ea_capture_r9: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    req_valid_i |=> fault_ea_o == $past(req_ea_i))
    else $error("p_ea_capture_r9");

  // R2: floating-point class is judged on the two low address bits only
  p_fp_word_r2: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    req_valid_i && req_class_i == CLS_FP |=> fault_o == $past(|req_ea_i[1:0]))
    else $error("p_fp_word_r2");

  // R5: string class follows the byte-order mode alone
  p_string_le_r5: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    req_valid_i && req_class_i == CLS_STR |=> fault_o == $past(little_endian_i))
    else $error("p_string_le_r5");

  // R7: cache-block zero follows the memory attributes alone
  p_zero_attr_r7: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    req_valid_i && req_class_i == CLS_ZERO |=> fault_o == $past(wr_thru_i | cache_inh_i))
    else $error("p_zero_attr_r7");

  // R8: unassigned class codes never fault
  p_spare_cls_r8: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    req_valid_i && req_class_i > CLS_ZERO |=> !fault_o)
    else $error("p_spare_cls_r8");
endmodule

// File: tb/tb_lsu_align_check.sv
`timescale 1ns/1ps
module tb_lsu_align_check;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          valid;
  logic [2:0]    cls;
  logic [AW-1:0] ea;
  logic [1:0]    sz;
  logic          le, wt, ci;
  logic          fault;
  logic [AW-1:0] fault_ea;

  int  errs   = 0;
  int  checks = 0;
  bit  done   = 0;

  always #2.5 clk = ~clk;

  lsu_align_check #(.ADDR_W(AW)) dut (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .req_valid_i     (valid),
    .req_class_i     (cls),
    .req_ea_i        (ea),
    .req_size_i      (sz),
    .little_endian_i (le),
    .wr_thru_i       (wt),
    .cache_inh_i     (ci),
    .fault_o         (fault),
    .fault_ea_o      (fault_ea)
  );

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected verdict, from the requirements
  function automatic bit model(int c, int lo, int s, bit l, bit w, bit i);
    bit wmis = (lo % 4) != 0;
    bit nmis = (lo % (1 << s)) != 0;
    case (c)
      0: return l && nmis;   // R6
      1: return wmis;        // R2
      2: return wmis || l;   // R3
      3: return wmis;        // R4
      4: return l;           // R5
      5: return w || i;      // R7
      default: return 1'b0;  // R8
    endcase
  endfunction

  function automatic string req_of(int c);
    case (c)
      0: return "R6";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL R9 watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [AW-1:0] held_ea;
    int n = 0;
    rst_n = 1'b0;
    valid = 1'b0; cls = '0; ea = '0; sz = '0; le = 1'b0; wt = 1'b0; ci = 1'b0;

    repeat (3) @(negedge clk);
    check("R1", "fault in reset", fault, 0);
    check("R1", "ea in reset", fault_ea, 0);
    // a faulting valid request during reset must not show
    valid = 1'b1; cls = 3'd4; le = 1'b1; ea = 32'hDEAD_BEEF;
    @(negedge clk);
    check("R1", "fault with request in reset", fault, 0);
    check("R1", "ea with request in reset", fault_ea, 0);
    valid = 1'b0; le = 1'b0; ea = '0; cls = '0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // exhaustive sweep: class x low bits x size x byte order x attributes
    for (int c = 0; c < 8; c++)
      for (int lo = 0; lo < 8; lo++)
        for (int s = 0; s < 4; s++)
          for (int l = 0; l < 2; l++)
            for (int w = 0; w < 2; w++)
              for (int i = 0; i < 2; i++) begin
                logic [AW-1:0] a;
                n++;
                a = ((32'(n) * 32'h9E37_79B1) & ~32'h7) | 32'(lo);
                valid = 1'b1; cls = 3'(c); ea = a; sz = 2'(s);
                le = l[0]; wt = w[0]; ci = i[0];
                @(negedge clk);
                check(req_of(c), "verdict", fault,
                      model(c, lo, s, l[0], w[0], i[0]));
                check("R9", "captured ea", fault_ea, a);
              end

    // R10: invalid faulting-looking cycle after a clean verdict
    valid = 1'b1; cls = 3'd0; ea = 32'h1234_5670; sz = 2'd3; le = 1'b0; wt = 1'b0; ci = 1'b0;
    @(negedge clk);
    check("R10", "clean setup", fault, 0);
    valid = 1'b0; cls = 3'd1; ea = 32'h0000_0003; le = 1'b1; wt = 1'b1;
    @(negedge clk);
    check("R10", "flag after invalid", fault, 0);
    check("R10", "ea after invalid", fault_ea, 32'h1234_5670);

    // R10: a held fault survives several invalid cycles
    valid = 1'b1; cls = 3'd4; ea = 32'hCAFE_0000; le = 1'b1;
    @(negedge clk);
    check("R5", "string in little-endian", fault, 1);
    held_ea = fault_ea;
    valid = 1'b0; cls = 3'd0; ea = 32'h0; le = 1'b0; wt = 1'b0; ci = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", "fault held", fault, 1);
    check("R10", "ea held", fault_ea, held_ea);

    // R1: reset asserted mid-run clears at once
    rst_n = 1'b0;
    #1;
    check("R1", "fault after mid-run reset", fault, 0);
    check("R1", "ea after mid-run reset", fault_ea, 0);

    finish_run();
  end
endmodule